// File: doc/BRIEF.md
# Counter Overflow Request Enable Unit

This block decides which event counters may raise a request outside the core when they overflow. It receives one overflow pulse from a cycle counter and one from each of several event counters. Two enable masks with the same layout select the overflows that matter. One mask feeds an active-low system reset request. The other feeds an active-high debug request.

Each mask has two register addresses. A write to the set address turns on every enable written as one. A write to the clear address turns off every enable written as one. A read of either address returns the current mask. Access comes over a simple single-cycle register bus with a privilege flag. A user-access enable input admits unprivileged accesses. Once raised, a request holds until its acknowledge strobe arrives or until the enable of the counter that caused it is switched off.

Top module: `ovf_req_enable`

## Requirements
- R1: Within each mask word, bit 31 enables the cycle counter and bits 2, 1 and 0 enable event counters 2, 1 and 0. Register word addresses: 0 sets reset enables, 1 clears reset enables, 2 sets debug enables, 3 clears debug enables.
- R2: Bits 30 to 3 of every mask word read as zero, and writes to them have no effect.
- R3: A granted read of either the set address or the clear address of a mask returns that mask on `bus_rdata` one cycle after the read strobe.
- R4: A set write enables each bit written as one. Bits written as zero keep their current value.
- R5: A clear write disables each bit written as one. Bits written as zero keep their current value.
- R6: An overflow pulse on a counter whose reset enable is on drives `rst_req_n` low in the next cycle. An overflow on a disabled counter leaves it high.
- R7: The debug mask is separate from the reset mask. An enabled overflow drives `dbg_req` high in the next cycle and does not touch `rst_req_n`.
- R8: An access with `bus_priv` high is always granted. An access with `bus_priv` low is granted only while `user_en` is high.
- R9: A denied access changes no mask. It returns zero read data and raises `bus_err` for exactly one cycle.
- R10: A raised request stays asserted until its clear strobe (`rst_ack` or `dbg_ack`) or until every enable of the counters that raised it is cleared. An overflow in the same cycle as the strobe keeps the request asserted.
- R11: After reset both masks are zero, `rst_req_n` is high, `dbg_req` is low and `bus_err` is low.
- R12: An overflow in the same cycle as a set write that enables the same counter raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_priv | input | 1 | Access is privileged |
| user_en | input | 1 | Admit unprivileged accesses |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle pulse for a denied access |
| cyc_ovf | input | 1 | Cycle counter overflow pulse |
| evt_ovf | input | N_EVT | Event counter overflow pulses |
| rst_ack | input | 1 | Clears the held reset request |
| dbg_ack | input | 1 | Clears the held debug request |
| rst_req_n | output | 1 | Reset request, active low |
| dbg_req | output | 1 | Debug request, active high |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, three event counters and the cycle counter enable at bit 31. The reserved span between bit 3 and bit 30 is therefore wide, so all-ones writes and reserved-only clears show that the reserved bits stay zero. With three event counters and the cycle counter, the bench can enable one counter, overflow another, and then check that each request path responds only to its own mask.

// File: rtl/ovf_req_pkg.sv
package ovf_req_pkg;

    // Word addresses of the four mask access points
    typedef enum logic [1:0] {
        SEL_RST_SET = 2'd0,
        SEL_RST_CLR = 2'd1,
        SEL_DBG_SET = 2'd2,
        SEL_DBG_CLR = 2'd3
    } reg_sel_e;

    // Number of request paths: reset and debug
    localparam int unsigned N_PATH = 2;
    localparam int unsigned PATH_RST = 0;
    localparam int unsigned PATH_DBG = 1;

endpackage

// File: rtl/ovf_req_lane.sv
module ovf_req_lane #(
    parameter int unsigned NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_bits,
    input  logic [NB-1:0] clr_bits,
    input  logic [NB-1:0] ovf,
    input  logic          ack,
    output logic [NB-1:0] mask,
    output logic          pend_any
);

    typedef struct packed {
        logic [NB-1:0] mask;
        logic [NB-1:0] pend;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        logic [NB-1:0] kept;
        st_d      = st_q;
        // new enables take effect before the overflow is examined
        st_d.mask = (st_q.mask | set_bits) & ~clr_bits;
        kept      = ack ? '0 : st_q.pend;
        // a pending bit survives only while its enable is on
        st_d.pend = (kept | (ovf & st_d.mask)) & st_d.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask     = st_q.mask;
    assign pend_any = |st_q.pend;

endmodule

// File: rtl/ovf_req_bus.sv
module ovf_req_bus
    import ovf_req_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned N_EVT   = 3,
    parameter int unsigned CYC_BIT = 31,
    localparam int unsigned NB     = N_EVT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    input  logic              user_en,
    input  logic [NB-1:0]     rst_mask,
    input  logic [NB-1:0]     dbg_mask,
    output logic [NB-1:0]     rst_set,
    output logic [NB-1:0]     rst_clr,
    output logic [NB-1:0]     dbg_set,
    output logic [NB-1:0]     dbg_clr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } bus_st_t;

    bus_st_t st_d, st_q;

    logic              granted;
    logic              sel_ok;
    reg_sel_e          sel;
    logic [NB-1:0]     wr_bits;
    logic [DATA_W-1:0] rst_word;
    logic [DATA_W-1:0] dbg_word;

    assign granted = bus_priv | user_en;
    assign sel     = reg_sel_e'(bus_addr[1:0]);
    assign sel_ok  = (bus_addr >> 2) == '0;

    // Compress a bus word into the compact enable vector and back again.
    // Index N_EVT of the compact vector is the cycle counter.
    always_comb begin
        rst_word = '0;
        dbg_word = '0;
        for (int i = 0; i < N_EVT; i++) begin
            wr_bits[i]  = bus_wdata[i];
            rst_word[i] = rst_mask[i];
            dbg_word[i] = dbg_mask[i];
        end
        wr_bits[N_EVT]    = bus_wdata[CYC_BIT];
        rst_word[CYC_BIT] = rst_mask[N_EVT];
        dbg_word[CYC_BIT] = dbg_mask[N_EVT];
    end

    always_comb begin
        logic do_wr;
        do_wr   = bus_wr && granted && sel_ok;
        rst_set = (do_wr && sel == SEL_RST_SET) ? wr_bits : '0;
        rst_clr = (do_wr && sel == SEL_RST_CLR) ? wr_bits : '0;
        dbg_set = (do_wr && sel == SEL_DBG_SET) ? wr_bits : '0;
        dbg_clr = (do_wr && sel == SEL_DBG_CLR) ? wr_bits : '0;
    end

    always_comb begin
        st_d       = st_q;
        st_d.err   = (bus_rd || bus_wr) && !granted;
        st_d.rdata = '0;
        if (bus_rd && granted && sel_ok) begin
            case (sel)
                SEL_RST_SET, SEL_RST_CLR: st_d.rdata = rst_word;
                default:                  st_d.rdata = dbg_word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;

endmodule

// File: rtl/ovf_req_enable.sv
module ovf_req_enable
    import ovf_req_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned N_EVT   = 3,
    parameter int unsigned CYC_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_priv,
    input  logic              user_en,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              cyc_ovf,
    input  logic [N_EVT-1:0]  evt_ovf,
    input  logic              rst_ack,
    input  logic              dbg_ack,
    output logic              rst_req_n,
    output logic              dbg_req
);

    localparam int unsigned NB = N_EVT + 1;

    logic [NB-1:0]     set_v  [N_PATH];
    logic [NB-1:0]     clr_v  [N_PATH];
    logic [NB-1:0]     mask_v [N_PATH];
    logic [N_PATH-1:0] ack_v;
    logic [N_PATH-1:0] pend_v;
    logic [NB-1:0]     ovf_vec;
    logic [NB-1:0]     rst_mask;
    logic [NB-1:0]     dbg_mask;

    assign ovf_vec         = {cyc_ovf, evt_ovf};
    assign ack_v[PATH_RST] = rst_ack;
    assign ack_v[PATH_DBG] = dbg_ack;
    assign rst_mask        = mask_v[PATH_RST];
    assign dbg_mask        = mask_v[PATH_DBG];

    ovf_req_bus #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .N_EVT   (N_EVT),
        .CYC_BIT (CYC_BIT)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_priv  (bus_priv),
        .user_en   (user_en),
        .rst_mask  (rst_mask),
        .dbg_mask  (dbg_mask),
        .rst_set   (set_v[PATH_RST]),
        .rst_clr   (clr_v[PATH_RST]),
        .dbg_set   (set_v[PATH_DBG]),
        .dbg_clr   (clr_v[PATH_DBG]),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        ovf_req_lane #(
            .NB (NB)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_v[p]),
            .clr_bits (clr_v[p]),
            .ovf      (ovf_vec),
            .ack      (ack_v[p]),
            .mask     (mask_v[p]),
            .pend_any (pend_v[p])
        );
    end

    assign rst_req_n = ~pend_v[PATH_RST];
    assign dbg_req   = pend_v[PATH_DBG];

endmodule

// File: rtl/ovf_req_enable_chk.sv
module ovf_req_enable_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_EVT  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_priv,
    input logic              user_en,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              cyc_ovf,
    input logic [N_EVT-1:0]  evt_ovf,
    input logic              rst_ack,
    input logic              dbg_ack,
    input logic              rst_req_n,
    input logic              dbg_req,
    input logic [N_EVT:0]    rst_mask,
    input logic [N_EVT:0]    dbg_mask
);

    logic denied;
    assign denied = (bus_rd || bus_wr) && !bus_priv && !user_en;

    assert_denied_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        denied |=> bus_err && bus_rdata == '0);

    assert_denied_keeps_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        denied |=> $stable(rst_mask) && $stable(dbg_mask));

    assert_err_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_err);

    assert_priv_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_priv |=> !bus_err);

    assert_rst_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n |-> rst_mask != '0);

    assert_dbg_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |-> dbg_mask != '0);

    assert_cyc_ovf_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ovf && rst_mask[N_EVT] && !bus_wr) |=> !rst_req_n);

    assert_rst_ack_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_ack && !cyc_ovf && evt_ovf == '0) |=> rst_req_n);

    assert_dbg_ack_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ack && !cyc_ovf && evt_ovf == '0) |=> !dbg_req);

endmodule

bind ovf_req_enable ovf_req_enable_chk #(
    .DATA_W (DATA_W),
    .N_EVT  (N_EVT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .user_en   (user_en),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .cyc_ovf   (cyc_ovf),
    .evt_ovf   (evt_ovf),
    .rst_ack   (rst_ack),
    .dbg_ack   (dbg_ack),
    .rst_req_n (rst_req_n),
    .dbg_req   (dbg_req),
    .rst_mask  (rst_mask),
    .dbg_mask  (dbg_mask)
);

// File: tb/ovf_req_enable_bench.sv
module ovf_req_enable_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int N_EVT      = 3;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_priv = 1'b0;
    logic              user_en = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_err;
    logic              cyc_ovf = 1'b0;
    logic [N_EVT-1:0]  evt_ovf = '0;
    logic              rst_ack = 1'b0;
    logic              dbg_ack = 1'b0;
    logic              rst_req_n;
    logic              dbg_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovf_req_enable #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .N_EVT   (N_EVT),
        .CYC_BIT (31)
    ) u_ovf_req_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_priv  (bus_priv),
        .user_en   (user_en),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .cyc_ovf   (cyc_ovf),
        .evt_ovf   (evt_ovf),
        .rst_ack   (rst_ack),
        .dbg_ack   (dbg_ack),
        .rst_req_n (rst_req_n),
        .dbg_req   (dbg_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one bus write; error flag is returned from the cycle after
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input logic priv, output logic err);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = priv;
        @(negedge clk);
        err = bus_err;
        bus_wr = 1'b0; bus_wdata = '0; bus_priv = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic priv,
                      output logic [31:0] d, output logic err);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_priv = priv;
        @(negedge clk);
        d = bus_rdata; err = bus_err;
        bus_rd = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic pulse_ovf(input logic cyc, input logic [N_EVT-1:0] evt);
        @(negedge clk);
        cyc_ovf = cyc; evt_ovf = evt;
        @(negedge clk);
        cyc_ovf = 1'b0; evt_ovf = '0;
    endtask

    task automatic pulse_ack(input logic r, input logic g);
        @(negedge clk);
        rst_ack = r; dbg_ack = g;
        @(negedge clk);
        rst_ack = 1'b0; dbg_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        check("R11 rst_req_n after reset", 32'(rst_req_n), 32'd1);
        check("R11 dbg_req after reset", 32'(dbg_req), 32'd0);
        check("R11 bus_err after reset", 32'(bus_err), 32'd0);
        rd(4'd0, 1'b1, d, e);
        check("R11 reset mask zero", d, 32'h0);
        rd(4'd2, 1'b1, d, e);
        check("R11 debug mask zero", d, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d; logic e;
        wr(4'd0, 32'hFFFF_FFFF, 1'b1, e);
        rd(4'd0, 1'b1, d, e);
        check("R1 R2 set all reads mapped bits only", d, 32'h8000_0007);
        rd(4'd1, 1'b1, d, e);
        check("R3 clear address reads mask", d, 32'h8000_0007);
        wr(4'd1, 32'h0000_0001, 1'b1, e);
        rd(4'd0, 1'b1, d, e);
        check("R5 clear one bit", d, 32'h8000_0006);
        wr(4'd0, 32'h0, 1'b1, e);
        rd(4'd0, 1'b1, d, e);
        check("R4 zero set write no change", d, 32'h8000_0006);
        wr(4'd1, 32'h7FFF_FFF8, 1'b1, e);
        rd(4'd0, 1'b1, d, e);
        check("R2 reserved clear ignored", d, 32'h8000_0006);
        wr(4'd0, 32'h0000_0001, 1'b1, e);
        rd(4'd0, 1'b1, d, e);
        check("R4 set merges", d, 32'h8000_0007);
        rd(4'd2, 1'b1, d, e);
        check("R7 debug mask untouched", d, 32'h0);
        wr(4'd1, 32'hFFFF_FFFF, 1'b1, e);
        rd(4'd0, 1'b1, d, e);
        check("R5 clear all", d, 32'h0);
    endtask

    task automatic t_reset_path();
        logic e;
        wr(4'd0, 32'h0000_0002, 1'b1, e);
        pulse_ovf(1'b0, 3'b001);
        check("R6 disabled overflow ignored", 32'(rst_req_n), 32'd1);
        pulse_ovf(1'b0, 3'b010);
        check("R6 enabled overflow asserts", 32'(rst_req_n), 32'd0);
        check("R7 debug unaffected", 32'(dbg_req), 32'd0);
        repeat (3) @(negedge clk);
        check("R10 request held", 32'(rst_req_n), 32'd0);
        pulse_ack(1'b1, 1'b0);
        check("R10 ack releases", 32'(rst_req_n), 32'd1);
        wr(4'd0, 32'h8000_0000, 1'b1, e);
        pulse_ovf(1'b1, 3'b000);
        check("R1 R6 cycle counter overflow", 32'(rst_req_n), 32'd0);
        wr(4'd1, 32'h8000_0000, 1'b1, e);
        check("R10 clearing enable releases", 32'(rst_req_n), 32'd1);
        wr(4'd1, 32'hFFFF_FFFF, 1'b1, e);
    endtask

    task automatic t_debug_path();
        logic [31:0] d; logic e;
        wr(4'd2, 32'h0000_0004, 1'b1, e);
        rd(4'd3, 1'b1, d, e);
        check("R3 R7 debug clear address reads", d, 32'h0000_0004);
        pulse_ovf(1'b0, 3'b100);
        check("R7 debug request high", 32'(dbg_req), 32'd1);
        check("R7 reset request idle", 32'(rst_req_n), 32'd1);
        // ack coinciding with a new overflow keeps the request
        @(negedge clk);
        dbg_ack = 1'b1; evt_ovf = 3'b100;
        @(negedge clk);
        dbg_ack = 1'b0; evt_ovf = '0;
        check("R10 overflow beats ack", 32'(dbg_req), 32'd1);
        pulse_ack(1'b0, 1'b1);
        check("R10 debug ack releases", 32'(dbg_req), 32'd0);
        wr(4'd3, 32'hFFFF_FFFF, 1'b1, e);
    endtask

    task automatic t_access();
        logic [31:0] d; logic e;
        user_en = 1'b0;
        wr(4'd0, 32'h0000_0001, 1'b0, e);
        check("R9 denied write err", 32'(e), 32'd1);
        @(negedge clk);
        check("R9 err lasts one cycle", 32'(bus_err), 32'd0);
        rd(4'd0, 1'b1, d, e);
        check("R9 denied write no change", d, 32'h0);
        check("R8 privileged read no err", 32'(e), 32'd0);
        wr(4'd0, 32'h0000_0001, 1'b1, e);
        rd(4'd0, 1'b0, d, e);
        check("R9 denied read zero", d, 32'h0);
        check("R9 denied read err", 32'(e), 32'd1);
        user_en = 1'b1;
        rd(4'd0, 1'b0, d, e);
        check("R8 user read allowed", d, 32'h0000_0001);
        check("R8 user read no err", 32'(e), 32'd0);
        wr(4'd1, 32'h0000_0001, 1'b0, e);
        rd(4'd0, 1'b1, d, e);
        check("R8 user clear allowed", d, 32'h0);
        user_en = 1'b0;
    endtask

    task automatic t_same_cycle();
        logic e;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0000_0002; bus_priv = 1'b1;
        evt_ovf = 3'b010;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; bus_priv = 1'b0; evt_ovf = '0;
        check("R12 set with overflow raises", 32'(rst_req_n), 32'd0);
        pulse_ack(1'b1, 1'b0);
        check("R12 released after ack", 32'(rst_req_n), 32'd1);
        wr(4'd1, 32'hFFFF_FFFF, 1'b1, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_reset_path();
        t_debug_path();
        t_access();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule